// File: doc/BRIEF.md
# Sequential Code Checker with Timed Result Indicators

This block reads a four-bit entry code from an 8-bit switch bus, one bit per step, over four consecutive steps. It then decides whether the entry is correct and lights one of three indicators. A busy lamp stays on while bits are collected and while the decision is made. A pass lamp lights for three seconds when every collected bit is 1. A fail lamp lights for two seconds otherwise. After either result the block starts a fresh attempt.

Every state has its own reload value, and one down-counter times the states. The counter is reloaded when it reaches zero, and the state advances on the cycle where the counter reads 1. The clock frequency and the length of each collection step are parameters, so the result intervals come out in whole seconds of the real clock. Switch debouncing is left to the surrounding logic.

Top module: `code_lock_timer`

## Requirements
- R1: An active-high `rst` forces `led` to `100` immediately, without waiting for a clock edge. After release, the first collection step lasts STEP_CYCLES-1 clock cycles.
- R2: The four collection steps read `sw[7]`, `sw[6]`, `sw[5]` and `sw[3]`, in that order. Each bit is taken at the clock edge that ends its step. A 0 in any one of them leads to the fail result.
- R3: `led` reads `100` (bit 2 = busy) during the four collection steps and the decision step. Each of these five steps lasts STEP_CYCLES cycles, apart from the first step after reset (see R1).
- R4: When all four collected bits are 1, the decision step is followed by `led` = `010` (bit 1 = pass) for exactly 3*CLK_HZ cycles.
- R5: When any collected bit is 0, the decision step is followed by `led` = `001` (bit 0 = fail) for exactly 2*CLK_HZ cycles.
- R6: After a pass or fail interval, `led` returns to `100` and a new attempt begins. The new attempt's result depends only on bits collected during it, and a reset in the middle of a result interval likewise starts a clean attempt.
- R7: `sw[4]` and `sw[2:0]` never affect the result. A sampled bit's value at any edge other than the one that ends its step also has no effect.
- R8: Outside reset, exactly one bit of `led` is 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ cycles per second |
| rst | input | 1 | Asynchronous reset, active high |
| sw | input | 8 | Switch bus carrying the entry code |
| led | output | 3 | One-hot lamps: bit 2 busy, bit 1 pass, bit 0 fail |

## Verification
Each collection step takes its bit at the clock edge where that step ends. `led` is a register, so it moves to the next state's pattern on that same edge and is visible from the following half cycle. The bench drives `sw` on falling edges and compares `led` on every falling edge with a behavioural model. The model counts the cycles left in the current phase and changes phase on the edge where one cycle remains. Independent run-length monitors confirm the pass interval is 3*CLK_HZ cycles, the fail interval is 2*CLK_HZ cycles, and the busy interval is 5*STEP_CYCLES cycles (one fewer straight after reset). One stimulus mode raises the sampled bits only in the cycle just before each step's ending edge, which shows that only that edge matters.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

    typedef enum logic [2:0] {
        ST_GET0   = 3'd0,
        ST_GET1   = 3'd1,
        ST_GET2   = 3'd2,
        ST_GET3   = 3'd3,
        ST_DECIDE = 3'd4,
        ST_PASS   = 3'd5,
        ST_FAIL   = 3'd6
    } lock_state_e;

    localparam logic [2:0] LAMP_BUSY = 3'b100;
    localparam logic [2:0] LAMP_PASS = 3'b010;
    localparam logic [2:0] LAMP_FAIL = 3'b001;

    typedef struct packed {
        lock_state_e st;
        logic [3:0]  code;
        logic [2:0]  lamp;
    } lock_regs_t;

    function automatic logic [2:0] lamp_for(lock_state_e s);
        case (s)
            ST_PASS: return LAMP_PASS;
            ST_FAIL: return LAMP_FAIL;
            default: return LAMP_BUSY;
        endcase
    endfunction

endpackage

// File: rtl/lock_reload_sel.sv
module lock_reload_sel
    import code_lock_pkg::*;
#(
    parameter int CW        = 8,
    parameter int STEP_LOAD = 3,
    parameter int PASS_LOAD = 29,
    parameter int FAIL_LOAD = 19
) (
    input  lock_state_e    st_i,
    output logic [CW-1:0]  load_o
);

    always_comb begin
        case (st_i)
            ST_PASS: load_o = CW'(PASS_LOAD);
            ST_FAIL: load_o = CW'(FAIL_LOAD);
            default: load_o = CW'(STEP_LOAD);
        endcase
    end

endmodule

// File: rtl/lock_dwell_counter.sv
module lock_dwell_counter #(
    parameter int CW      = 8,
    parameter int RST_VAL = 3,
    parameter int MAX_VAL = 29
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] load_i,
    output logic          step_end_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q == '0) begin
            cnt_d = load_i;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= CW'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign step_end_o = (cnt_q == CW'(1));

    // R3: a spent counter picks up the current state's dwell on the next edge
    a_r3_zero_reloads: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |=> (cnt_q == $past(load_i)));

    // R3: the count never exceeds the longest dwell
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= CW'(MAX_VAL)));

endmodule

// File: rtl/code_lock_timer.sv
module code_lock_timer
    import code_lock_pkg::*;
#(
    parameter int                CLK_HZ      = 50_000_000,
    parameter int                STEP_CYCLES = 4,
    parameter logic [3:0][2:0]   SAMPLE_POS  = {3'd3, 3'd5, 3'd6, 3'd7}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sw,
    output logic [2:0] led
);

    localparam int STEP_LOAD = STEP_CYCLES - 1;
    localparam int PASS_LOAD = 3 * CLK_HZ - 1;
    localparam int FAIL_LOAD = 2 * CLK_HZ - 1;
    localparam int MAX_LOAD  = (PASS_LOAD > STEP_LOAD) ? PASS_LOAD : STEP_LOAD;
    localparam int CW        = $clog2(MAX_LOAD + 1) + 1;

    lock_regs_t    regs_d, regs_q;
    logic [CW-1:0] load;
    logic          step_end;
    logic [2:0]    pick;
    logic          sample;

    lock_reload_sel #(
        .CW        (CW),
        .STEP_LOAD (STEP_LOAD),
        .PASS_LOAD (PASS_LOAD),
        .FAIL_LOAD (FAIL_LOAD)
    ) u_reload (
        .st_i   (regs_q.st),
        .load_o (load)
    );

    lock_dwell_counter #(
        .CW      (CW),
        .RST_VAL (STEP_LOAD),
        .MAX_VAL (MAX_LOAD)
    ) u_dwell (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .step_end_o (step_end)
    );

    assign pick   = SAMPLE_POS[regs_q.st[1:0]];
    assign sample = sw[pick];

    always_comb begin
        regs_d = regs_q;
        if (step_end) begin
            case (regs_q.st)
                ST_GET0, ST_GET1, ST_GET2, ST_GET3: begin
                    regs_d.code[regs_q.st[1:0]] = sample;
                    regs_d.st = lock_state_e'(regs_q.st + 3'd1);
                end
                ST_DECIDE: begin
                    regs_d.st = (regs_q.code == 4'hF) ? ST_PASS : ST_FAIL;
                end
                default: begin
                    regs_d.st   = ST_GET0;
                    regs_d.code = '0;
                end
            endcase
        end
        regs_d.lamp = lamp_for(regs_d.st);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            regs_q.st   <= ST_GET0;
            regs_q.code <= '0;
            regs_q.lamp <= LAMP_BUSY;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign led = regs_q.lamp;

    // R8: one lamp at a time
    a_r8_led_onehot: assert property (@(posedge clk) disable iff (rst)
        ($countones(led) == 1));

    // R4: pass lamp only follows a fully set code
    a_r4_pass_needs_code: assert property (@(posedge clk) disable iff (rst)
        $rose(led[1]) |-> ($past(regs_q.code) == 4'hF));

    // R5: fail lamp only follows a code with a zero
    a_r5_fail_needs_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(led[0]) |-> ($past(regs_q.code) != 4'hF));

    // R6: end of a result starts a clean attempt
    a_r6_fresh_attempt: assert property (@(posedge clk) disable iff (rst)
        $rose(led[2]) |-> (regs_q.code == 4'h0 && regs_q.st == ST_GET0));

endmodule

// File: tb/tb_code_lock_timer.sv
module tb_code_lock_timer;

    localparam int CLK_PERIOD = 10;
    localparam int HZ   = 5;
    localparam int STEP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sw  = 8'h00;
    logic [2:0] led;

    always #(CLK_PERIOD / 2) clk = ~clk;

    code_lock_timer #(.CLK_HZ(HZ), .STEP_CYCLES(STEP)) dut (
        .clk (clk),
        .rst (rst),
        .sw  (sw),
        .led (led)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pos_of(input int k);
        case (k)
            0: return 7;
            1: return 6;
            2: return 5;
            default: return 3;
        endcase
    endfunction

    function automatic int dur_of(input int p);
        if (p < 5) return STEP;
        if (p == 5) return 3 * HZ;
        return 2 * HZ;
    endfunction

    // behavioural model: phase 0..3 collect, 4 decide, 5 pass, 6 fail
    int         ph, left, np;
    logic [3:0] mb;
    int         pass_cnt = 0;
    int         fail_cnt = 0;

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            ph   = 0;
            left = STEP - 1;
            mb   = 4'h0;
        end else if (left == 1) begin
            if (ph < 4) begin
                mb[ph] = sw[pos_of(ph)];
                np = ph + 1;
            end else if (ph == 4) begin
                np = (mb == 4'hF) ? 5 : 6;
                if (np == 5) pass_cnt++;
                else fail_cnt++;
            end else begin
                np = 0;
                mb = 4'h0;
            end
            ph   = np;
            left = dur_of(np);
        end else begin
            left--;
        end
    end

    // per-cycle comparison, run-length monitors and stimulus
    int         mode = 0;
    logic [2:0] prev_led = 3'b000;
    int         run = 0;
    bit         skip_run = 1'b1;
    bit         first_busy = 1'b1;
    logic [2:0] exp_led;

    always @(negedge clk) begin
        if (!rst) begin
            exp_led = (ph == 5) ? 3'b010 : (ph == 6) ? 3'b001 : 3'b100;
            check(led === exp_led, (ph == 5) ? "R4" : (ph == 6) ? "R5" : "R3",
                  int'(led), int'(exp_led));
            check($countones(led) == 1, "R8", $countones(led), 1);
            if (led === prev_led) begin
                run++;
            end else begin
                if (!skip_run) begin
                    if (prev_led == 3'b010) check(run == 3 * HZ, "R4 length", run, 3 * HZ);
                    else if (prev_led == 3'b001) check(run == 2 * HZ, "R5 length", run, 2 * HZ);
                    else begin
                        check(run == (first_busy ? 5 * STEP - 1 : 5 * STEP),
                              first_busy ? "R1 first step" : "R3 length",
                              run, first_busy ? 5 * STEP - 1 : 5 * STEP);
                        first_busy = 1'b0;
                    end
                end else if (prev_led == 3'b100) begin
                    first_busy = 1'b0;
                end
                skip_run = 1'b0;
                run      = 1;
                prev_led = led;
            end
            case (mode)
                1: sw = 8'($urandom) | 8'hE8;
                2: sw = (8'($urandom) | 8'hE0) & 8'hF7;
                3: sw = (left == 1 && ph < 4) ? ((8'($urandom) & 8'h17) | 8'hE8)
                                              : (8'($urandom) & 8'h17);
                10, 11, 12, 13: sw = (8'($urandom) | 8'hE8) & ~(8'h01 << pos_of(mode - 10));
                default: sw = 8'($urandom);
            endcase
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        check(led == 3'b100, "R1 async", int'(led), 4);
        skip_run   = 1'b1;
        first_busy = 1'b1;
        prev_led   = 3'b000;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic run_mode(input int m, input int n, input int expect_pass, input string req);
        int p0;
        int f0;
        while (ph < 5) @(negedge clk);
        while (ph != 0) @(negedge clk);
        mode = m;
        p0 = pass_cnt;
        f0 = fail_cnt;
        while (pass_cnt + fail_cnt < p0 + f0 + n) @(negedge clk);
        if (expect_pass == 1) check(pass_cnt - p0 == n, req, pass_cnt - p0, n);
        else if (expect_pass == 0) check(fail_cnt - f0 == n, req, fail_cnt - f0, n);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check(led == 3'b100, "R1 during reset", int'(led), 4);
        #1 rst = 1'b0;
        mode = 1;
        run_mode(1, 2, 1, "R4 all sampled bits high");
        run_mode(2, 2, 0, "R6 fresh bits after pass, bit 3 low");
        run_mode(10, 1, 0, "R2 bit 7 low");
        run_mode(11, 1, 0, "R2 bit 6 low");
        run_mode(12, 1, 0, "R2 bit 5 low");
        run_mode(13, 1, 0, "R2 bit 3 low");
        run_mode(3, 3, 1, "R7 only ending edge matters");
        run_mode(0, 4, -1, "R5 random");
        mode = 1;
        while (ph != 5) @(negedge clk);
        repeat (3) @(negedge clk);
        do_reset();
        run_mode(1, 1, 1, "R6 pass after mid-result reset");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule